// File: doc/BRIEF.md
# Oversampling Nine-Bit Serial Receiver

This block takes an asynchronous serial line and recovers 11-bit frames. Each frame has a low start bit, eight data bits sent least significant bit first, a ninth bit, and a stop bit. The line is first synchronized. It is then sampled at sixteen times the bit rate. The bit rate is the system clock divided by 32 or by 64, chosen by one input.

A falling edge on an idle line restarts the slice counter, so each bit period is divided into sixteen slices that are aligned to that edge. Every bit is decided by a two-of-three vote over the samples in slices 8, 9 and 10. A start bit that votes high is treated as noise, and the receiver goes back to waiting for a falling edge.

At the middle of the stop bit, the frame is offered to the output registers. It is loaded only if two conditions hold:
- The previous frame has been consumed, which means the sticky done flag is low.
- Either multiprocessor mode is off, or the ninth bit is 1.

In multiprocessor mode, this lets a node ignore data frames until an address frame arrives.

Top module: `mp_serial_rx`

## Requirements
- R1: After reset, `rx_done` is 0, `rx_data` is 0x00 and `rx_ninth` is 0.
- R2: While `rx_en` is low, the receiver stays idle. A frame sent in that time changes none of the outputs.
- R3: The frame is one 0 start bit, then data bits d0..d7, then the ninth bit, then the stop bit. The data bits appear on `rx_data[0]..rx_data[7]` and the ninth bit on `rx_ninth`. With `rate_fast`=1 a bit lasts 32 clocks. With `rate_fast`=0 a bit lasts 64 clocks.
- R4: Each bit is the majority of three samples taken at slices 8, 9 and 10 after the start edge. A single flipped sample in that window, including one on the start bit, does not change the received frame.
- R5: If the start bit votes 1, the frame is abandoned without touching the outputs, and a following valid frame is received.
- R6: The stop bit value is not checked. A frame whose stop bit is 0 is accepted like any other.
- R7: With `mp_mode`=1, a frame whose ninth bit is 0 is discarded and one whose ninth bit is 1 is accepted. With `mp_mode`=0, both are accepted.
- R8: While `rx_done` is 1, a new frame is discarded, and `rx_data`, `rx_ninth` and `rx_done` keep their values.
- R9: `rx_done` stays set until `rx_done_clr` is 1. When a clear and a load fall in the same cycle, the data is loaded but `rx_done` ends at 0.
- R10: From the middle of the stop bit the receiver watches again for a falling edge. A frame that directly follows another with a single stop bit is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd | input | 1 | Serial input line, idle high |
| rx_en | input | 1 | Receive enable |
| mp_mode | input | 1 | Multiprocessor filtering: accept only frames whose ninth bit is 1 |
| rate_fast | input | 1 | 1: bit = 32 clocks, 0: bit = 64 clocks |
| rx_done_clr | input | 1 | Clears the receive-complete flag (wins over a set) |
| rx_data | output | 8 | Last accepted data byte |
| rx_ninth | output | 1 | Last accepted ninth bit |
| rx_done | output | 1 | Sticky receive-complete flag |

## Verification
The load of an accepted frame and a software clear of the done flag can land on the same clock edge. The bench provokes this by holding `rx_done_clr` high across the whole frame, so it is certainly high in the load cycle. It then judges the outcome at the ports: the new byte and ninth bit must be visible while `rx_done` stays 0. Random frames also mix pending flags, filter settings and single-sample glitches, so that the acceptance decision meets a full or empty flag in every combination.

// File: rtl/mprx_pkg.sv
package mprx_pkg;
  typedef enum logic [0:0] {
    RX_IDLE = 1'b0,
    RX_BUSY = 1'b1
  } rx_state_e;
endpackage

// File: rtl/mprx_rate_gen.sv
module mprx_rate_gen #(
  parameter int unsigned DIV_FAST = 2,
  parameter int unsigned DIV_SLOW = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rate_fast,
  output logic tick
);
  localparam int unsigned DIV_W = (DIV_SLOW > 1) ? $clog2(DIV_SLOW) : 1;

  logic [DIV_W-1:0] cnt_q, cnt_d, limit;

  always_comb begin
    limit = rate_fast ? DIV_W'(DIV_FAST - 1) : DIV_W'(DIV_SLOW - 1);
    tick  = (cnt_q >= limit);
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // ticks are never adjacent: at least two clocks per oversample slice
  assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/mprx_line_sync.sv
module mprx_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] stg_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[i] <= 1'b1;
          else        stg_q[i] <= din;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[i] <= 1'b1;
          else        stg_q[i] <= stg_q[i-1];
        end
      end
    end
  endgenerate

  assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/mprx_frame_fsm.sv
module mprx_frame_fsm
  import mprx_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              line,
  input  logic              rx_en,
  output logic              load,
  output logic [DATA_W-1:0] frame_data,
  output logic              frame_ninth
);
  localparam int unsigned PAY_W      = DATA_W + 1;
  localparam int unsigned FRAME_BITS = DATA_W + 3;
  localparam int unsigned SLICE_W    = $clog2(OVS);
  localparam int unsigned BIT_W      = $clog2(FRAME_BITS + 1);
  localparam logic [SLICE_W-1:0] SL_A = SLICE_W'(OVS / 2);
  localparam logic [SLICE_W-1:0] SL_B = SLICE_W'(OVS / 2 + 1);
  localparam logic [SLICE_W-1:0] SL_C = SLICE_W'(OVS / 2 + 2);
  localparam logic [BIT_W-1:0]   LAST = BIT_W'(FRAME_BITS - 1);

  rx_state_e          state_q, state_d;
  logic [SLICE_W-1:0] slice_q, slice_d, cur;
  logic [BIT_W-1:0]   bitn_q, bitn_d;
  logic [1:0]         samp_q, samp_d;
  logic [PAY_W-1:0]   shift_q, shift_d;
  logic               prev_q, prev_d;
  logic               vote, load_raw;

  always_comb begin
    state_d  = state_q;
    slice_d  = slice_q;
    bitn_d   = bitn_q;
    samp_d   = samp_q;
    shift_d  = shift_q;
    prev_d   = prev_q;
    load_raw = 1'b0;
    cur      = slice_q + 1'b1;
    vote     = (samp_q[0] & samp_q[1]) | (samp_q[0] & line) | (samp_q[1] & line);
    if (tick) begin
      prev_d = line;
      case (state_q)
        RX_IDLE: begin
          if (rx_en && prev_q && !line) begin
            state_d = RX_BUSY;
            slice_d = '0;
            bitn_d  = '0;
          end
        end
        RX_BUSY: begin
          slice_d = cur;
          if (cur == '0) bitn_d = bitn_q + 1'b1;
          if (cur == SL_A) samp_d[0] = line;
          if (cur == SL_B) samp_d[1] = line;
          if (cur == SL_C) begin
            if (bitn_q == '0) begin
              if (vote) state_d = RX_IDLE;       // false start
            end else if (bitn_q == LAST) begin
              load_raw = 1'b1;                    // mid stop bit
              state_d  = RX_IDLE;
            end else begin
              shift_d = {vote, shift_q[PAY_W-1:1]};
            end
          end
        end
        default: state_d = RX_IDLE;
      endcase
    end
    if (!rx_en) state_d = RX_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      slice_q <= '0;
      bitn_q  <= '0;
      samp_q  <= '0;
      shift_q <= '0;
      prev_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      slice_q <= slice_d;
      bitn_q  <= bitn_d;
      samp_q  <= samp_d;
      shift_q <= shift_d;
      prev_q  <= prev_d;
    end
  end

  assign load        = load_raw & rx_en;
  assign frame_data  = shift_q[DATA_W-1:0];
  assign frame_ninth = shift_q[PAY_W-1];

  assert_idle_when_disabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> state_q == RX_IDLE);

  assert_start_on_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RX_BUSY && $past(state_q) == RX_IDLE) |-> ($past(prev_q) && !$past(line)));

  assert_bit_index_R3: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == RX_BUSY |-> bitn_q <= LAST);
endmodule

// File: rtl/mp_serial_rx.sv
module mp_serial_rx #(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned OVS         = 16,
  parameter int unsigned DIV_FAST    = 2,
  parameter int unsigned DIV_SLOW    = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxd,
  input  logic              rx_en,
  input  logic              mp_mode,
  input  logic              rate_fast,
  input  logic              rx_done_clr,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_ninth,
  output logic              rx_done
);
  logic              tick, line, load, f_ninth, accept;
  logic [DATA_W-1:0] f_data;
  logic [DATA_W-1:0] data_q, data_d;
  logic              ninth_q, ninth_d, done_q, done_d;

  mprx_rate_gen #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) u_rate (
    .clk(clk), .rst_n(rst_n), .rate_fast(rate_fast), .tick(tick));

  mprx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rxd), .dout(line));

  mprx_frame_fsm #(.DATA_W(DATA_W), .OVS(OVS)) u_fsm (
    .clk(clk), .rst_n(rst_n), .tick(tick), .line(line), .rx_en(rx_en),
    .load(load), .frame_data(f_data), .frame_ninth(f_ninth));

  always_comb begin
    accept  = load && !done_q && (!mp_mode || f_ninth);
    data_d  = accept ? f_data  : data_q;
    ninth_d = accept ? f_ninth : ninth_q;
    if (rx_done_clr)  done_d = 1'b0;
    else if (accept)  done_d = 1'b1;
    else              done_d = done_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      ninth_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      data_q  <= data_d;
      ninth_q <= ninth_d;
      done_q  <= done_d;
    end
  end

  assign rx_data  = data_q;
  assign rx_ninth = ninth_q;
  assign rx_done  = done_q;

  assert_clear_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done_clr |=> !rx_done);

  assert_hold_when_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && !rx_done_clr) |=> ($stable(rx_data) && $stable(rx_ninth)));

  assert_mp_filter_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rx_done) && $past(mp_mode)) |-> rx_ninth);
endmodule

// File: tb/mp_serial_rx_tb_top.sv
module mp_serial_rx_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rxd = 1'b1, rx_en = 1'b0, mp_mode = 1'b0, rate_fast = 1'b1, rx_done_clr = 1'b0;
  logic [7:0] rx_data;
  logic       rx_ninth, rx_done;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [7:0] data_m = 8'h00;
  logic       ninth_m = 1'b0;
  logic       flag_m = 1'b0;

  always #10 clk = ~clk;

  mp_serial_rx dut_i (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .rx_en(rx_en), .mp_mode(mp_mode),
    .rate_fast(rate_fast), .rx_done_clr(rx_done_clr),
    .rx_data(rx_data), .rx_ninth(rx_ninth), .rx_done(rx_done));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit will_accept(input bit n);
    return rx_en && !flag_m && (!mp_mode || n);
  endfunction

  function automatic int slice_clks();
    return rate_fast ? 2 : 4;
  endfunction

  task automatic send_frame(input logic [7:0] d, input logic n, input logic stp,
                            input int gbit, input int gslice, input int tail_bits);
    for (int b = 0; b < 11; b++) begin
      logic v;
      if (b == 0)      v = 1'b0;
      else if (b <= 8) v = d[b-1];
      else if (b == 9) v = n;
      else             v = stp;
      for (int s = 0; s < 16; s++) begin
        rxd = (b == gbit && s == gslice) ? ~v : v;
        repeat (slice_clks()) @(negedge clk);
      end
    end
    rxd = 1'b1;
    repeat (tail_bits * 16 * slice_clks()) @(negedge clk);
  endtask

  task automatic frame_check(input logic [7:0] d, input logic n, input logic stp,
                             input int gbit, input int gslice, input string req);
    bit acc;
    acc = will_accept(n);
    send_frame(d, n, stp, gbit, gslice, 2);
    if (acc) begin
      data_m  = d;
      ninth_m = n;
      if (!rx_done_clr) flag_m = 1'b1;
    end
    check(rx_done == flag_m, req, rx_done, flag_m);
    check(rx_data == data_m, req, rx_data, data_m);
    check(rx_ninth == ninth_m, req, rx_ninth, ninth_m);
  endtask

  task automatic clear_flag();
    rx_done_clr = 1'b1;
    @(negedge clk);
    rx_done_clr = 1'b0;
    flag_m = 1'b0;
    check(rx_done == 1'b0, "R9 clear", rx_done, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected=<150000", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(rx_done == 1'b0, "R1 flag", rx_done, 0);
    check(rx_data == 8'h00, "R1 data", rx_data, 0);
    check(rx_ninth == 1'b0, "R1 ninth", rx_ninth, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2: disabled receiver ignores a frame
    frame_check(8'hA5, 1'b1, 1'b1, -1, 0, "R2 disabled");

    rx_en = 1'b1;
    repeat (40) @(negedge clk);
    // R3: both rates, clean frames
    rate_fast = 1'b1;
    frame_check(8'h3C, 1'b1, 1'b1, -1, 0, "R3 fast rate");
    clear_flag();
    rate_fast = 1'b0;
    repeat (8) @(negedge clk);
    frame_check(8'hC1, 1'b0, 1'b1, -1, 0, "R3 slow rate");
    clear_flag();

    // R4: single-sample glitches at slices 8..10, including the start bit
    rate_fast = 1'b1;
    frame_check(8'h5A, 1'b0, 1'b1, 0, 9, "R4 glitch start");
    clear_flag();
    frame_check(8'h81, 1'b1, 1'b1, 1, 8, "R4 glitch d0");
    clear_flag();
    frame_check(8'h7E, 1'b1, 1'b1, 9, 10, "R4 glitch ninth");
    clear_flag();

    // R5: false start pulses, then a good frame
    for (int k = 1; k <= 4; k += 3) begin
      rxd = 1'b0;
      repeat (k * slice_clks()) @(negedge clk);
      rxd = 1'b1;
      repeat (2 * 16 * slice_clks()) @(negedge clk);
      check(rx_done == 1'b0, "R5 false start flag", rx_done, 0);
      check(rx_data == data_m, "R5 false start data", rx_data, data_m);
    end
    frame_check(8'h96, 1'b0, 1'b1, -1, 0, "R5 after abort");
    clear_flag();

    // R6: stop bit low still accepted
    frame_check(8'h42, 1'b1, 1'b0, -1, 0, "R6 stop low");
    clear_flag();

    // R7: multiprocessor filter
    mp_mode = 1'b1;
    frame_check(8'h11, 1'b0, 1'b1, -1, 0, "R7 mp drop");
    frame_check(8'h22, 1'b1, 1'b1, -1, 0, "R7 mp accept");
    clear_flag();
    mp_mode = 1'b0;

    // R8: overrun discarded, R9 flag sticky
    frame_check(8'h33, 1'b0, 1'b1, -1, 0, "R8 first");
    frame_check(8'h44, 1'b1, 1'b1, -1, 0, "R8 overrun");
    repeat (200) @(negedge clk);
    check(rx_done == 1'b1, "R9 sticky", rx_done, 1);
    clear_flag();

    // R9: clear held across the load cycle
    rx_done_clr = 1'b1;
    frame_check(8'hE7, 1'b1, 1'b1, -1, 0, "R9 clear vs set");
    rx_done_clr = 1'b0;
    @(negedge clk);
    check(rx_done == 1'b0, "R9 after collision", rx_done, 0);

    // R10: back-to-back frames, first filtered, second accepted
    mp_mode = 1'b1;
    send_frame(8'h55, 1'b0, 1'b1, -1, 0, 0);
    frame_check(8'hAA, 1'b1, 1'b1, -1, 0, "R10 back to back");
    clear_flag();
    mp_mode = 1'b0;

    // random mix
    begin
      int unsigned seed_val;
      seed_val = $urandom(32'd1234);
      for (int i = 0; i < 24; i++) begin
        logic [7:0] d;
        logic n;
        int gb, gs;
        d  = 8'($urandom());
        n  = 1'($urandom());
        mp_mode   = 1'($urandom());
        rate_fast = 1'($urandom());
        gb = int'($urandom_range(0, 11)) - 1;
        gs = 8 + int'($urandom_range(0, 2));
        if (gb == 10) gb = -1;
        repeat (8) @(negedge clk);
        frame_check(d, n, 1'b1, gb, gs, "R7 R8 R4 random");
        if (flag_m && $urandom_range(0, 1) == 1) clear_flag();
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule